// File: doc/BRIEF.md
# Abacus-Coded Lookahead Binary Adder

This block adds two unsigned operands and a carry-in, producing a sum of the same width and a carry-out. It is purely combinational. Each operand is cut into 2-bit digits, and every digit is recoded as a row of three beads in thermometer form, so the number of set beads equals the digit value. For each digit position, the two bead rows are merged into a six-position thermometer total. That total, together with the incoming carry, is decoded back into a 2-bit result digit.

Carries are formed in lookahead fashion. Two positions of each digit's merged total act as that digit's generate and propagate terms. Inside a 4-bit unit, the carries are computed flat in two logic levels. Between units, the group carry ripples from one unit to the next. The operand width is a parameter and must be a multiple of 4. Widths of 8 and 32 bits are the intended uses.

Top module: `abacus_la_adder`

## Requirements
- R1: A 2-bit digit (d1,d0) is recoded into beads b2 = d1 AND d0, b1 = d1, b0 = d1 OR d0. The result is always one of 000, 001, 011, 111, and its count of ones equals the digit value.
- R2: The merged total of two bead rows is a 6-bit thermometer code: no set bit sits above a clear bit. Its count of ones equals the sum of the two bead counts.
- R3: A digit's 2-bit result equals (ones in the merged total + incoming carry) mod 4. This holds for every total from 0 to 7, which is all digit pairs and both carry values.
- R4: A digit's carry-out is the merged total's bit 3, OR bit 2 AND the incoming carry. It is 1 exactly when the total plus carry is 4 or more.
- R5: Within a 4-bit unit, the low digit uses the unit's carry-in, and its carry feeds the high digit. Example: 9 + 13 with carry-in 0 gives low nibble 0110 with a carry out of the unit, so the 8-bit sum is 22.
- R6: For any operands, {carryOut, sumOut} equals opA + opB + carryIn. The width is a parameter that must be a multiple of 4.
- R7: The carry-out of each 4-bit unit is the carry-in of the next unit up. An all-ones operand plus carry-in 1 wraps the sum to zero and sets carryOut.
- R8: The block is correct at both 8-bit and 32-bit widths.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| opA | input | WIDTH | First unsigned operand |
| opB | input | WIDTH | Second unsigned operand |
| carryIn | input | 1 | Carry into the least significant digit |
| sumOut | output | WIDTH | Sum modulo 2^WIDTH |
| carryOut | output | 1 | Carry out of the most significant unit |

## Verification
The assertions watch every evaluation of the block. They check that each bead row and each merged total stays in thermometer form with the right count, that every digit's result and carry agree with its bead total, and that each unit and the whole word agree with the arithmetic sum. What only the bench's scenarios can show is behaviour tied to particular operand values. That covers the full 8-bit operand space with both carry values, the worked 9 + 13 case, carry chains running across every unit boundary of the 32-bit word, and the all-ones and all-zeros extremes.

// File: rtl/abacus_pkg.sv
package abacus_pkg;
  localparam int DIGIT_BITS = 2;
  localparam int BEAD_BITS  = 3;
  localparam int MERGE_BITS = 2 * BEAD_BITS;
  localparam int UNIT_BITS  = 4;
  localparam int UNIT_DIGITS = UNIT_BITS / DIGIT_BITS;

  typedef logic [BEAD_BITS-1:0]  beadT;
  typedef logic [MERGE_BITS-1:0] mergeT;

  // lookahead strobes handed from a digit to its unit
  typedef struct packed {
    logic gen;
    logic prop;
  } digitLaT;

  function automatic beadT encodePair(input logic [DIGIT_BITS-1:0] pair);
    beadT beads;
    beads[2] = pair[1] & pair[0];
    beads[1] = pair[1];
    beads[0] = pair[1] | pair[0];
    return beads;
  endfunction
endpackage

// File: rtl/abacus_digit.sv
module abacus_digit
  import abacus_pkg::*;
(
  input  logic [DIGIT_BITS-1:0] aPair,
  input  logic [DIGIT_BITS-1:0] bPair,
  input  logic                  carryIn,
  output logic [DIGIT_BITS-1:0] sumPair,
  output digitLaT               laTerms
);
  beadT  aBeads;
  beadT  bBeads;
  mergeT kSum;

  assign aBeads = encodePair(aPair);
  assign bBeads = encodePair(bPair);

  // the addend's bead row selects how far the augend's beads move up
  always_comb begin
    case (aBeads)
      3'b000:  kSum = {3'b000, bBeads};
      3'b001:  kSum = {2'b00, bBeads, 1'b1};
      3'b011:  kSum = {1'b0, bBeads, 2'b11};
      default: kSum = {bBeads, 3'b111};
    endcase
  end

  // parity of the total gives bit 0; bit 1 is set for totals 2,3,6,7
  always_comb begin
    sumPair[0] = (^kSum) ^ carryIn;
    if (carryIn)
      sumPair[1] = (kSum[0] & ~kSum[2]) | kSum[4];
    else
      sumPair[1] = (kSum[1] & ~kSum[3]) | kSum[5];
  end

  assign laTerms.gen  = kSum[3];
  assign laTerms.prop = kSum[2];

  always_comb begin
    // R1
    bead_code_chk: assert ((((aBeads + 3'd1) & aBeads) == 3'd0) &&
                           ($countones(aBeads) == int'(aPair)))
      else $error("bead row not a thermometer of its digit");
    // R2
    merge_thermo_chk: assert ((((kSum + 6'd1) & kSum) == 6'd0) &&
                              ($countones(kSum) == int'(aPair) + int'(bPair)))
      else $error("merged total malformed");
    // R3
    digit_sum_chk: assert (int'(sumPair) == (($countones(kSum) + int'(carryIn)) % 4))
      else $error("digit result disagrees with bead total");
    // R4
    digit_carry_chk: assert ((laTerms.gen | (laTerms.prop & carryIn)) ==
                             (($countones(kSum) + int'(carryIn)) >= 4))
      else $error("digit carry disagrees with bead total");
  end
endmodule

// File: rtl/abacus_unit4.sv
module abacus_unit4
  import abacus_pkg::*;
(
  input  logic [UNIT_BITS-1:0] unitA,
  input  logic [UNIT_BITS-1:0] unitB,
  input  logic                 carryIn,
  output logic [UNIT_BITS-1:0] unitSum,
  output logic                 carryOut
);
  digitLaT              laTerms  [UNIT_DIGITS];
  logic [UNIT_DIGITS-1:0] digitCarry;

  // flat two-level carries inside the unit
  assign digitCarry[0] = carryIn;
  assign digitCarry[1] = laTerms[0].gen | (laTerms[0].prop & carryIn);
  assign carryOut = laTerms[1].gen
                  | (laTerms[1].prop & laTerms[0].gen)
                  | (laTerms[1].prop & laTerms[0].prop & carryIn);

  for (genvar d = 0; d < UNIT_DIGITS; d++) begin : g_digit
    abacus_digit u_digit (
      .aPair   (unitA[d*DIGIT_BITS +: DIGIT_BITS]),
      .bPair   (unitB[d*DIGIT_BITS +: DIGIT_BITS]),
      .carryIn (digitCarry[d]),
      .sumPair (unitSum[d*DIGIT_BITS +: DIGIT_BITS]),
      .laTerms (laTerms[d])
    );
  end

  always_comb begin
    // R5
    unit_sum_chk: assert ({carryOut, unitSum} ==
                          ({1'b0, unitA} + {1'b0, unitB} + {4'd0, carryIn}))
      else $error("unit total wrong");
  end
endmodule

// File: rtl/abacus_la_adder.sv
module abacus_la_adder
  import abacus_pkg::*;
#(
  parameter int WIDTH = 32
) (
  input  logic [WIDTH-1:0] opA,
  input  logic [WIDTH-1:0] opB,
  input  logic             carryIn,
  output logic [WIDTH-1:0] sumOut,
  output logic             carryOut
);
  localparam int NUM_UNITS = WIDTH / UNIT_BITS;

  logic [NUM_UNITS:0] groupCarry;
  logic [WIDTH:0]     refTotal;

  assign groupCarry[0] = carryIn;

  for (genvar u = 0; u < NUM_UNITS; u++) begin : g_unit
    abacus_unit4 u_unit (
      .unitA    (opA[u*UNIT_BITS +: UNIT_BITS]),
      .unitB    (opB[u*UNIT_BITS +: UNIT_BITS]),
      .carryIn  (groupCarry[u]),
      .unitSum  (sumOut[u*UNIT_BITS +: UNIT_BITS]),
      .carryOut (groupCarry[u+1])
    );
  end

  assign carryOut = groupCarry[NUM_UNITS];
  assign refTotal = {1'b0, opA} + {1'b0, opB} + {{WIDTH{1'b0}}, carryIn};

  always_comb begin
    // R6
    word_sum_chk: assert ({carryOut, sumOut} == refTotal)
      else $error("word total wrong");
  end
endmodule

// File: tb/abacus_la_adder_tb.sv
module abacus_la_adder_tb;
  logic clk = 1'b0;
  always #4 clk = ~clk;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  logic [31:0] a32 = '0, b32 = '0, s32;
  logic        c32 = 1'b0, co32;
  logic [7:0]  a8 = '0, b8 = '0, s8;
  logic        c8 = 1'b0, co8;

  abacus_la_adder #(.WIDTH(32)) u_dut (
    .opA(a32), .opB(b32), .carryIn(c32), .sumOut(s32), .carryOut(co32));
  abacus_la_adder #(.WIDTH(8)) u_dut8 (
    .opA(a8), .opB(b8), .carryIn(c8), .sumOut(s8), .carryOut(co8));

  task automatic apply8(input logic [7:0] a, input logic [7:0] b, input logic c,
                        input string req);
    logic [8:0] exp;
    a8 = a; b8 = b; c8 = c;
    #2;
    exp = {1'b0, a} + {1'b0, b} + {8'd0, c};
    checks++;
    if ({co8, s8} !== exp) begin
      errors++;
      $display("FAIL %s: %0d+%0d+%0d got %0d expected %0d", req, a, b, c, {co8, s8}, exp);
    end
    #2;
  endtask

  task automatic apply32(input logic [31:0] a, input logic [31:0] b, input logic c,
                         input string req);
    logic [32:0] exp;
    a32 = a; b32 = b; c32 = c;
    #2;
    exp = {1'b0, a} + {1'b0, b} + {32'd0, c};
    checks++;
    if ({co32, s32} !== exp) begin
      errors++;
      $display("FAIL %s: %h+%h+%0d got %h expected %h", req, a, b, c, {co32, s32}, exp);
    end
    #2;
  endtask

  // all-zero inputs give an all-zero result on both widths
  task automatic test_idle_zero();
    apply32(32'd0, 32'd0, 1'b0, "R6 zero");
    apply8(8'd0, 8'd0, 1'b0, "R8 zero");
  endtask

  // every digit pair and carry in the lowest digit: totals 0..7 (R1 R2 R3 R4)
  task automatic test_digit_totals();
    for (int a = 0; a < 4; a++)
      for (int b = 0; b < 4; b++)
        for (int c = 0; c < 2; c++)
          apply8(8'(a), 8'(b), 1'(c), "R1 R2 R3 R4 digit total");
  endtask

  // R5: low digit carry into high digit, 9 + 13 = 22
  task automatic test_worked_case();
    a8 = 8'd9; b8 = 8'd13; c8 = 1'b0;
    #2;
    checks++;
    if (s8[3:0] !== 4'b0110 || s8[4] !== 1'b1 || co8 !== 1'b0) begin
      errors++;
      $display("FAIL R5: 9+13 got %b expected 000010110", {co8, s8});
    end
    #2;
    apply8(8'h03, 8'h01, 1'b0, "R5 low-to-high digit");
    apply8(8'h03, 8'h03, 1'b1, "R5 low-to-high digit with carry");
  endtask

  // R7: carries crossing every unit boundary
  task automatic test_group_ripple();
    apply32(32'hFFFF_FFFF, 32'd0, 1'b1, "R7 wrap to zero");
    apply32(32'hFFFF_FFFF, 32'hFFFF_FFFF, 1'b1, "R7 all ones");
    apply32(32'hFFFF_FFFF, 32'hFFFF_FFFF, 1'b0, "R7 all ones no carry");
    for (int u = 0; u < 8; u++)
      apply32(32'hF << (4*u), 32'h1 << (4*u), 1'b0, "R7 unit boundary");
    apply32(32'h0000_000F, 32'd0, 1'b1, "R7 unit carry");
  endtask

  // R6 R8: exhaustive 8-bit
  task automatic test_exhaustive8();
    for (int a = 0; a < 256; a++)
      for (int b = 0; b < 256; b++)
        for (int c = 0; c < 2; c++)
          apply8(8'(a), 8'(b), 1'(c), "R6 R8 exhaustive");
  endtask

  // R6 R8: random 32-bit
  task automatic test_random32();
    for (int i = 0; i < 2000; i++)
      apply32($urandom, $urandom, 1'($urandom), "R6 R8 random");
  endtask

  initial begin
    #1;
    test_idle_zero();
    test_digit_totals();
    test_worked_case();
    test_group_ripple();
    test_random32();
    test_exhaustive8();
    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: run hung, got timeout expected completion");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule